// File: doc/BRIEF.md
# Lock-Fenced Translation Cache

This block is a fully associative translation cache for device addresses. Each entry holds a tag word and a translation word. Software manages the entries through one lock register, which holds two pointers. The fence pointer marks off the entries below it as pinned. The next-slot pointer selects the entry that a read-back shows, and it advances after every fill. Software first stages a tag word and a translation word, then issues a fill command. A pinned fill lands on the fence and moves the fence up by one. A rotating fill lands on the lowest-numbered empty entry. Single entries can be dropped by address, and the whole cache can be cleared at once.

A combinational lookup port compares a 32-bit device address against every valid entry. The comparison honours each entry's own page size. On a hit the port returns the translated address: the physical page bits with the untranslated offset bits merged in. The cache holds 8 or 32 entries, chosen by a parameter.

Top module: `lkv_tlb`

## Requirements
- R1: After reset every entry is invalid, `lock_rd` reads 0, `sel_cam` reads 0 and no lookup hits.
- R2: `lock_rd` layout:
  - The next-slot pointer sits at bits 8:4.
  - The fence pointer, modulo the entry count, sits at bits 14:10.
  - Bit 15 is set when the fence equals the entry count.
  - All other bits read 0.
  A `lock_wr` loads the next-slot pointer from `lock_wdata` bits 8:4. It loads the fence from bits 14:10, or sets the fence to the entry count when bit 15 is set. The change is visible after one clock edge.
- R3: `sel_cam` and `sel_ram` always show the stored tag and translation words of the entry that the next-slot pointer selects.
- R4: A pinned fill (`load_go` with `load_keep`=1) does the following:
  - It writes the staged words into the entry at the fence.
  - It raises the fence by one.
  - It sets the next-slot pointer to the written index plus one, subject to R6.
- R5: A rotating fill (`load_keep`=0) does the following:
  - It writes the staged words into the lowest-numbered entry whose valid bit is clear.
  - It sets the next-slot pointer to that index plus one, subject to R6.
  - It leaves the fence unchanged.
- R6: When the incremented next-slot pointer equals the entry count, it wraps to the fence after the fill, taken modulo the entry count. It does not wrap to zero.
- R7: A fill is refused in two cases: any fill while the fence equals the entry count, and a rotating fill while no entry is invalid. A refused fill changes no state. It raises `load_busy` for exactly the one cycle after the command.
- R8: Tag word format:
  - Bits 31:12 hold the virtual page.
  - Bit 2 is the valid bit.
  - Bits 1:0 give the page size: 00 = 4 KB, 01 = 64 KB, 10 = 1 MB, 11 = 16 MB.

  Translation word bits 31:12 hold the physical page.
- R9: A lookup hits when the address falls in [page, page+size) of a valid entry. On a hit, `lk_pa` takes the physical bits above the page offset and the address bits below it. When several entries match, the lowest index wins.
- R10: An entry whose valid bit is clear never matches a lookup or a drop by address.
- R11: `flush_all` clears every valid bit and sets both pointers to 0. It has priority over `lock_wr` and `load_go`, which in turn have priority over `flush_one`.
- R12: `flush_one` clears the valid bit of the lowest-numbered valid entry whose range contains `flush_addr`. When no entry contains the address, nothing changes.
- R13: The entry count parameter accepts only 8 or 32, and any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_wr | input | 1 | Write strobe for the lock register |
| lock_wdata | input | 32 | Lock register write data |
| lock_rd | output | 32 | Lock register read value |
| stage_cam_we | input | 1 | Stage a tag word |
| stage_cam_d | input | 32 | Tag word to stage |
| stage_ram_we | input | 1 | Stage a translation word |
| stage_ram_d | input | 32 | Translation word to stage |
| load_go | input | 1 | Fill command |
| load_keep | input | 1 | 1 = pinned fill, 0 = rotating fill |
| load_busy | output | 1 | One-cycle refusal pulse after a fill command |
| sel_cam | output | 32 | Tag word of the selected entry |
| sel_ram | output | 32 | Translation word of the selected entry |
| flush_one | input | 1 | Drop one entry by address |
| flush_addr | input | 32 | Address for the drop |
| flush_all | input | 1 | Clear the whole cache |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated address |

## Verification
A wrong pointer is visible on `lock_rd` one clock edge after the command that corrupted it. It also shows up on the very next fill, which lands in an entry whose contents then appear on `sel_cam`/`sel_ram` or on a lookup in the same cycle. A lost or stray valid bit shows up at once on `lk_hit`, and at the next rotating fill as a wrong choice of slot or a wrong refusal. The directed scenarios force each of these paths:
- wraps of the next-slot pointer,
- a completely pinned cache,
- invalid staged entries,
- page-size masking at 64 KB, 1 MB and 16 MB.

// File: rtl/lkv_tlb_pkg.sv
package lkv_tlb_pkg;

   localparam int WORD_W    = 32;
   localparam int PAGE_LSB  = 12;
   localparam int PAGE_W    = WORD_W - PAGE_LSB;
   localparam int VALID_BIT = 2;
   localparam int FLD_W     = 5;
   localparam int VICT_LSB  = 4;
   localparam int BASE_LSB  = 10;
   localparam int FULL_BIT  = 15;

   typedef enum logic [1:0] {
      PG_4K  = 2'b00,
      PG_64K = 2'b01,
      PG_1M  = 2'b10,
      PG_16M = 2'b11
   } pgsz_e;

   // Page-number bits that take part in the compare for a given size
   function automatic logic [PAGE_W-1:0] keep_mask(input logic [1:0] sz);
      logic [PAGE_W-1:0] m;
      m = '1;
      case (pgsz_e'(sz))
         PG_4K:  m = '1;
         PG_64K: m = {{(PAGE_W-4){1'b1}}, 4'h0};
         PG_1M:  m = {{(PAGE_W-8){1'b1}}, 8'h00};
         PG_16M: m = {{(PAGE_W-12){1'b1}}, 12'h000};
         default: m = '1;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/lkv_tlb_match.sv
module lkv_tlb_match
   import lkv_tlb_pkg::*;
#(
   parameter int N_ENT = 32
) (
   input  logic [WORD_W-1:0]             addr,
   input  logic [N_ENT-1:0][WORD_W-1:0]  cams,
   output logic [N_ENT-1:0]              hits
);

   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      logic [PAGE_W-1:0] keep;
      logic [PAGE_W-1:0] diff;
      assign keep    = keep_mask(cams[i][1:0]);
      assign diff    = (addr[WORD_W-1:PAGE_LSB] ^ cams[i][WORD_W-1:PAGE_LSB]) & keep;
      assign hits[i] = cams[i][VALID_BIT] && (diff == '0);
   end

endmodule

// File: rtl/lkv_tlb_prio.sv
module lkv_tlb_prio #(
   parameter int N_REQ = 32,
   localparam int IW   = $clog2(N_REQ)
) (
   input  logic [N_REQ-1:0] req,
   output logic             any,
   output logic [IW-1:0]    idx
);

   always_comb begin
      idx = '0;
      for (int i = N_REQ - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/lkv_tlb.sv
module lkv_tlb
   import lkv_tlb_pkg::*;
#(
   parameter int N_ENT = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lock_wr,
   input  logic [31:0] lock_wdata,
   output logic [31:0] lock_rd,
   input  logic        stage_cam_we,
   input  logic [31:0] stage_cam_d,
   input  logic        stage_ram_we,
   input  logic [31:0] stage_ram_d,
   input  logic        load_go,
   input  logic        load_keep,
   output logic        load_busy,
   output logic [31:0] sel_cam,
   output logic [31:0] sel_ram,
   input  logic        flush_one,
   input  logic [31:0] flush_addr,
   input  logic        flush_all,
   input  logic [31:0] lk_addr,
   output logic        lk_hit,
   output logic [31:0] lk_pa
);

   localparam int IW = $clog2(N_ENT);
   localparam int PW = IW + 1;
   localparam logic [PW-1:0] N_PTR = PW'(N_ENT);

   // R13: only two legal sizes
   if (!(N_ENT == 8 || N_ENT == 32)) begin : g_bad_size
      $error("lkv_tlb: N_ENT must be 8 or 32");
   end

   logic [N_ENT-1:0][WORD_W-1:0] cam_q;
   logic [N_ENT-1:0][WORD_W-1:0] ram_q;
   logic [WORD_W-1:0]            stg_cam_q;
   logic [WORD_W-1:0]            stg_ram_q;
   logic [PW-1:0]                base_q;
   logic [IW-1:0]                vict_q;
   logic                         busy_q;

   // Empty-slot search
   logic [N_ENT-1:0] invalid_v;
   logic             inv_any;
   logic [IW-1:0]    inv_idx;

   for (genvar i = 0; i < N_ENT; i++) begin : g_inv
      assign invalid_v[i] = !cam_q[i][VALID_BIT];
   end

   lkv_tlb_prio #(.N_REQ(N_ENT)) u_inv_prio (
      .req (invalid_v),
      .any (inv_any),
      .idx (inv_idx)
   );

   // Lookup path
   logic [N_ENT-1:0] lk_hits;
   logic             lk_any;
   logic [IW-1:0]    lk_idx;

   lkv_tlb_match #(.N_ENT(N_ENT)) u_lk_match (
      .addr (lk_addr),
      .cams (cam_q),
      .hits (lk_hits)
   );

   lkv_tlb_prio #(.N_REQ(N_ENT)) u_lk_prio (
      .req (lk_hits),
      .any (lk_any),
      .idx (lk_idx)
   );

   // Drop-by-address path
   logic [N_ENT-1:0] fl_hits;
   logic             fl_any;
   logic [IW-1:0]    fl_idx;

   lkv_tlb_match #(.N_ENT(N_ENT)) u_fl_match (
      .addr (flush_addr),
      .cams (cam_q),
      .hits (fl_hits)
   );

   lkv_tlb_prio #(.N_REQ(N_ENT)) u_fl_prio (
      .req (fl_hits),
      .any (fl_any),
      .idx (fl_idx)
   );

   // Fill decision
   logic          full;
   logic          reject;
   logic [IW-1:0] tgt;
   logic [PW-1:0] base_nxt;
   logic [PW-1:0] step;
   logic [IW-1:0] vict_nxt;

   always_comb begin
      full     = (base_q == N_PTR);
      reject   = full || (!load_keep && !inv_any);
      tgt      = load_keep ? base_q[IW-1:0] : inv_idx;
      base_nxt = load_keep ? base_q + PW'(1) : base_q;
      step     = {1'b0, tgt} + PW'(1);
      vict_nxt = (step == N_PTR) ? base_nxt[IW-1:0] : step[IW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cam_q     <= '0;
         ram_q     <= '0;
         stg_cam_q <= '0;
         stg_ram_q <= '0;
         base_q    <= '0;
         vict_q    <= '0;
         busy_q    <= 1'b0;
      end else begin
         busy_q <= 1'b0;
         if (stage_cam_we) stg_cam_q <= stage_cam_d;
         if (stage_ram_we) stg_ram_q <= stage_ram_d;
         if (flush_all) begin
            for (int i = 0; i < N_ENT; i++) cam_q[i][VALID_BIT] <= 1'b0;
            base_q <= '0;
            vict_q <= '0;
         end else if (lock_wr) begin
            base_q <= lock_wdata[FULL_BIT] ? N_PTR : {1'b0, lock_wdata[BASE_LSB +: IW]};
            vict_q <= lock_wdata[VICT_LSB +: IW];
         end else if (load_go) begin
            if (reject) begin
               busy_q <= 1'b1;
            end else begin
               cam_q[tgt] <= stg_cam_q;
               ram_q[tgt] <= stg_ram_q;
               base_q     <= base_nxt;
               vict_q     <= vict_nxt;
            end
         end else if (flush_one && fl_any) begin
            cam_q[fl_idx][VALID_BIT] <= 1'b0;
         end
      end
   end

   // Lock register read-back; the field widening depends on the entry count
   logic [FLD_W-1:0] base_fld;
   logic [FLD_W-1:0] vict_fld;

   if (IW == FLD_W) begin : g_fld_full
      assign base_fld = base_q[IW-1:0];
      assign vict_fld = vict_q;
   end else begin : g_fld_narrow
      assign base_fld = {{(FLD_W-IW){1'b0}}, base_q[IW-1:0]};
      assign vict_fld = {{(FLD_W-IW){1'b0}}, vict_q};
   end

   assign lock_rd   = {16'h0000, full, base_fld, 1'b0, vict_fld, 4'h0};
   assign load_busy = busy_q;
   assign sel_cam   = cam_q[vict_q];
   assign sel_ram   = ram_q[vict_q];

   logic [PAGE_W-1:0] lk_keep;
   assign lk_keep = keep_mask(cam_q[lk_idx][1:0]);
   assign lk_hit  = lk_any;
   assign lk_pa   = {(ram_q[lk_idx][WORD_W-1:PAGE_LSB] & lk_keep) |
                     (lk_addr[WORD_W-1:PAGE_LSB] & ~lk_keep),
                     lk_addr[PAGE_LSB-1:0]};

   logic unused_lock_bits;
   assign unused_lock_bits = ^lock_wdata;

endmodule

// File: rtl/lkv_tlb_chk.sv
module lkv_tlb_chk #(
   parameter int N_ENT = 32,
   localparam int IW   = $clog2(N_ENT),
   localparam int PW   = IW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flush_all,
   input logic          lock_wr,
   input logic [31:0]   lock_wdata,
   input logic          load_go,
   input logic          load_keep,
   input logic          load_busy,
   input logic [31:0]   lock_rd,
   input logic          lk_hit,
   input logic [PW-1:0] base_q,
   input logic [IW-1:0] vict_q
);

   assert_base_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      base_q <= PW'(N_ENT));

   assert_flush_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (lock_rd == 32'h0) && !lk_hit);

   assert_full_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_go && !flush_all && !lock_wr && base_q == PW'(N_ENT))
      |=> load_busy && $stable(base_q) && $stable(vict_q));

   assert_pinned_fence_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_go && load_keep && !flush_all && !lock_wr && base_q != PW'(N_ENT))
      |=> base_q == $past(base_q) + PW'(1));

   assert_lock_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && !flush_all) |=> vict_q == $past(lock_wdata[4 +: IW]));

   assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_busy |-> $past(load_go));

endmodule

bind lkv_tlb lkv_tlb_chk #(.N_ENT(N_ENT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush_all  (flush_all),
   .lock_wr    (lock_wr),
   .lock_wdata (lock_wdata),
   .load_go    (load_go),
   .load_keep  (load_keep),
   .load_busy  (load_busy),
   .lock_rd    (lock_rd),
   .lk_hit     (lk_hit),
   .base_q     (base_q),
   .vict_q     (vict_q)
);

// File: tb/lkv_tlb_bench.sv
`timescale 1ns/1ps
module lkv_tlb_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lock_wr = 1'b0;
   logic [31:0] lock_wdata = '0;
   logic [31:0] lock_rd;
   logic        stage_cam_we = 1'b0;
   logic [31:0] stage_cam_d = '0;
   logic        stage_ram_we = 1'b0;
   logic [31:0] stage_ram_d = '0;
   logic        load_go = 1'b0;
   logic        load_keep = 1'b0;
   logic        load_busy;
   logic [31:0] sel_cam;
   logic [31:0] sel_ram;
   logic        flush_one = 1'b0;
   logic [31:0] flush_addr = '0;
   logic        flush_all = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_hit;
   logic [31:0] lk_pa;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lkv_tlb u_lkv_tlb (
      .clk(clk), .rst_n(rst_n),
      .lock_wr(lock_wr), .lock_wdata(lock_wdata), .lock_rd(lock_rd),
      .stage_cam_we(stage_cam_we), .stage_cam_d(stage_cam_d),
      .stage_ram_we(stage_ram_we), .stage_ram_d(stage_ram_d),
      .load_go(load_go), .load_keep(load_keep), .load_busy(load_busy),
      .sel_cam(sel_cam), .sel_ram(sel_ram),
      .flush_one(flush_one), .flush_addr(flush_addr), .flush_all(flush_all),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_pa(lk_pa)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic edge_done();
      @(posedge clk);
      #1;
   endtask

   task automatic stage(input logic [31:0] c, input logic [31:0] r);
      @(negedge clk);
      stage_cam_we = 1'b1; stage_cam_d = c;
      stage_ram_we = 1'b1; stage_ram_d = r;
      edge_done();
      stage_cam_we = 1'b0; stage_ram_we = 1'b0;
   endtask

   task automatic fill(input logic keep, output logic busy);
      @(negedge clk);
      load_go = 1'b1; load_keep = keep;
      edge_done();
      load_go = 1'b0;
      busy = load_busy;
   endtask

   task automatic write_lock(input logic [31:0] v);
      @(negedge clk);
      lock_wr = 1'b1; lock_wdata = v;
      edge_done();
      lock_wr = 1'b0;
   endtask

   task automatic drop(input logic [31:0] a);
      @(negedge clk);
      flush_one = 1'b1; flush_addr = a;
      edge_done();
      flush_one = 1'b0;
   endtask

   task automatic look(input string rq, input logic [31:0] a,
                       input logic hit, input logic [31:0] pa);
      lk_addr = a;
      #1;
      chk(rq, "lookup hit", {31'b0, lk_hit}, {31'b0, hit});
      if (hit) chk(rq, "lookup pa", lk_pa, pa);
   endtask

   task automatic t_reset();
      chk("R1", "lock after reset", lock_rd, 32'h0);
      chk("R1", "sel_cam after reset", sel_cam, 32'h0);
      look("R1", 32'h0000_0000, 1'b0, '0);
   endtask

   task automatic t_pinned();
      logic b;
      stage(32'h1000_0004, 32'hA000_0000);
      fill(1'b1, b);
      chk("R4", "busy", {31'b0, b}, 32'h0);
      chk("R4", "lock after pinned fill", lock_rd, 32'h0000_0410);
      look("R9", 32'h1000_0ABC, 1'b1, 32'hA000_0ABC);
      stage(32'h2000_0005, 32'hB000_0000);
      fill(1'b1, b);
      chk("R4", "lock after second pinned fill", lock_rd, 32'h0000_0820);
      look("R8", 32'h2000_F123, 1'b1, 32'hB000_F123);
   endtask

   task automatic t_rotating();
      logic b;
      stage(32'h3000_0006, 32'hC000_0000);
      fill(1'b0, b);
      chk("R5", "lock after rotating fill", lock_rd, 32'h0000_0830);
      look("R8", 32'h300A_BCDE, 1'b1, 32'hC00A_BCDE);
      stage(32'h4000_0007, 32'hD000_0000);
      fill(1'b0, b);
      chk("R5", "lock after second rotating fill", lock_rd, 32'h0000_0840);
      look("R9", 32'h40FF_FFFF, 1'b1, 32'hD0FF_FFFF);
      look("R9", 32'h4100_0000, 1'b0, '0);
   endtask

   task automatic t_readback();
      write_lock(32'h0000_0820);
      chk("R2", "lock write echo", lock_rd, 32'h0000_0820);
      chk("R3", "sel_cam entry 2", sel_cam, 32'h3000_0006);
      chk("R3", "sel_ram entry 2", sel_ram, 32'hC000_0000);
      write_lock(32'h0000_0800);
      chk("R3", "sel_cam entry 0", sel_cam, 32'h1000_0004);
   endtask

   task automatic t_invalid_entry();
      logic b;
      stage(32'h5000_0000, 32'hE000_0000);
      fill(1'b0, b);
      chk("R5", "lock after fill into slot 4", lock_rd, 32'h0000_0850);
      look("R10", 32'h5000_0000, 1'b0, '0);
      write_lock(32'h0000_0840);
      chk("R10", "stored word of invalid entry", sel_ram, 32'hE000_0000);
   endtask

   task automatic t_drop();
      logic b;
      drop(32'h2000_8000);
      look("R12", 32'h2000_0000, 1'b0, '0);
      look("R12", 32'h1000_0000, 1'b1, 32'hA000_0000);
      drop(32'h7777_0000);
      chk("R12", "lock after missed drop", lock_rd, 32'h0000_0840);
      look("R12", 32'h3000_0000, 1'b1, 32'hC000_0000);
      look("R12", 32'h4000_0000, 1'b1, 32'hD000_0000);
      stage(32'h6000_0004, 32'hF000_0000);
      fill(1'b0, b);
      chk("R5", "rotating fill reuses lowest hole", lock_rd, 32'h0000_0820);
      look("R5", 32'h6000_0010, 1'b1, 32'hF000_0010);
   endtask

   task automatic t_flush_all();
      @(negedge clk);
      flush_all = 1'b1; load_go = 1'b1; load_keep = 1'b1;
      edge_done();
      flush_all = 1'b0; load_go = 1'b0;
      chk("R11", "lock after flush_all", lock_rd, 32'h0);
      chk("R11", "no busy when flush_all wins", {31'b0, load_busy}, 32'h0);
      look("R11", 32'h1000_0000, 1'b0, '0);
      look("R11", 32'h6000_0000, 1'b0, '0);
   endtask

   task automatic t_fill_all();
      logic b;
      for (int k = 0; k < 32; k++) begin
         stage(((k + 1) << 20) | 32'h4, (k + 32'h100) << 12);
         fill(1'b1, b);
         if (k == 30) chk("R4", "lock at fence 31", lock_rd, 32'h0000_7DF0);
      end
      chk("R6", "pinned wrap with full fence", lock_rd, 32'h0000_8000);
      look("R9", 32'h0050_0000, 1'b1, 32'h0010_4000);
      look("R9", 32'h0200_0000, 1'b1, 32'h0011_F000);
      fill(1'b1, b);
      chk("R7", "busy when fence full", {31'b0, b}, 32'h1);
      chk("R7", "lock unchanged when refused", lock_rd, 32'h0000_8000);
      edge_done();
      chk("R7", "busy is one cycle", {31'b0, load_busy}, 32'h0);
   endtask

   task automatic t_rot_wrap();
      logic b;
      write_lock(32'h0000_1000);
      chk("R2", "lock rewrite", lock_rd, 32'h0000_1000);
      drop(32'h0200_0123);
      look("R12", 32'h0200_0000, 1'b0, '0);
      stage(32'h7000_0004, 32'h1234_5000);
      fill(1'b0, b);
      chk("R6", "rotating wrap to fence", lock_rd, 32'h0000_1040);
      look("R5", 32'h7000_0FFF, 1'b1, 32'h1234_5FFF);
      fill(1'b0, b);
      chk("R7", "busy with no hole", {31'b0, b}, 32'h1);
      chk("R7", "lock unchanged", lock_rd, 32'h0000_1040);
      stage(32'h0880_0004, 32'h0990_0000);
      fill(1'b1, b);
      chk("R4", "pinned fill at fence 4", lock_rd, 32'h0000_1450);
      look("R4", 32'h0880_0004, 1'b1, 32'h0990_0004);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      edge_done();
      t_reset();
      t_pinned();
      t_rotating();
      t_readback();
      t_invalid_entry();
      t_drop();
      t_flush_all();
      t_fill_all();
      t_rot_wrap();
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule